// File: doc/BRIEF.md
# Synchronizable Multi-Channel Counter Group

This block holds six 16-bit up-counters that share one count enable. Each counter either runs alone or joins a synchronized set. Membership is chosen by one bit per channel in an 8-bit control register. A simple register bus reaches every counter, every compare register and the control register. Reads return data in the same cycle.

A bus write to the counter of a synchronized channel loads that value into every synchronized counter in the same clock. Each channel has a 2-bit clear-select input. It picks one of three behaviours: no clear, clear on the channel's own compare match, or clear whenever the synchronized set clears. A synchronized channel that clears on its own match becomes the clear source for the set. Every synchronized channel set to follow the set then loads zero in that same cycle. Channels outside the set are untouched by these events. With only one synchronization bit set, that channel behaves like an independent one.

Top module: `sync_counter_group`

## Requirements
- R1: After a synchronous active-low reset, every counter, every compare register and the control register read 0.
- R2: Control register bits 5..0 are the synchronization bits for channels 5..0. Bits 7..6 and all higher read-data bits always read 0, and writing 1 to them has no effect.
- R3: Bus address map: 0..5 are the counters of channels 0..5, 6..11 are the compare registers of channels 0..5, and 12 is the control register. Reads at 13..15 return 0, writes there change nothing, and read data follows the address in the same cycle.
- R4: A counter adds one on every clock edge where count_en is high, wraps from 16'hFFFF to 0, and holds its value when count_en is low.
- R5: A channel whose synchronization bit is 0 is unaffected by counter writes to, and clears of, any other channel.
- R6: A counter write to a channel whose synchronization bit is 1 loads the written value into every counter whose synchronization bit is 1, in the same clock.
- R7: With clear-select 01, a counter whose value equals its compare value on a clock edge where count_en is high becomes 0 instead of incrementing.
- R8: A channel with its synchronization bit set and clear-select 10 becomes 0 on any count_en edge where some synchronized channel with clear-select 01 matches. A channel with clear-select 10 but no synchronization bit is not cleared.
- R9: Clear-select 00 and 11 never clear the counter, even on a compare match.
- R10: A counter write (direct or through synchronized preset) takes priority over clearing and counting in the same cycle.
- R11: With a single synchronization bit set, a write to that channel's counter changes only that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_en | input | 1 | Shared count enable for all channels |
| clr_sel | input | 12 | Clear-select, 2 bits per channel, channel i at [2i+1:2i] |
| bus_addr | input | 4 | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 16 | Register bus write data |
| bus_rdata | output | 16 | Register bus read data, combinational from bus_addr |

## Verification
The presets are tried in three patterns: all channels independent, an alternating set of three channels, and a lone synchronized channel. Together they tell a true group broadcast apart from a write that lands only on its own channel or leaks into non-members. Clearing is tried with one compare source in a set that also holds a follower, a synchronized channel with clear-select 00, and an unsynchronized follower. This shows that a group clear needs both the bit and the select. One cycle combines a write, a compare match and counting. It tells whether the write wins over the clear and the increment. A counter started just below 16'hFFFF checks the wrap.

// File: rtl/scg_pkg.sv
// Package: shared types and constants of the counter group.
// Assumes: clear-select encodings are fixed at two bits.
package scg_pkg;
    typedef enum logic [1:0] {
        CLR_NONE  = 2'b00,
        CLR_OWN   = 2'b01,
        CLR_GROUP = 2'b10,
        CLR_RSVD  = 2'b11
    } clr_sel_e;

    localparam int CTRL_W = 8;
endpackage

// File: rtl/scg_regbus.sv
// Register bus decode and read mux for the counter group.
// Counters sit at 0..NCH-1, compares at NCH..2*NCH-1, control at 2*NCH.
// Assumes: 2*NCH+1 addresses fit in AW bits; reads are combinational.
module scg_regbus #(
    parameter int NCH = 6,
    parameter int CW  = 16,
    parameter int AW  = 4
) (
    input  logic                     bus_wr,
    input  logic [AW-1:0]            bus_addr,
    input  logic [NCH-1:0][CW-1:0]   cnt_all,
    input  logic [NCH-1:0][CW-1:0]   cmp_all,
    input  logic [NCH-1:0]           sync_q,
    output logic [NCH-1:0]           cnt_wr_oh,
    output logic [NCH-1:0]           cmp_wr_oh,
    output logic                     ctrl_wr,
    output logic [CW-1:0]            rdata
);
    localparam int CMP_BASE  = NCH;
    localparam int CTRL_ADDR = 2 * NCH;

    // Per-channel write strobes from address decode.
    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign cnt_wr_oh[i] = bus_wr && (bus_addr == AW'(i));
        assign cmp_wr_oh[i] = bus_wr && (bus_addr == AW'(CMP_BASE + i));
    end
    assign ctrl_wr = bus_wr && (bus_addr == AW'(CTRL_ADDR));

    // Read mux: unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(i))            rdata = cnt_all[i];
            if (bus_addr == AW'(CMP_BASE + i)) rdata = cmp_all[i];
        end
        if (bus_addr == AW'(CTRL_ADDR)) rdata = CW'(sync_q);
    end
endmodule

// File: rtl/scg_sync_ctrl.sv
// Synchronization control: holds the per-channel sync bits and turns
// bus writes and compare hits into per-channel preset and clear enables.
// Assumes: own_hit is already qualified by count_en and clear-select 01.
module scg_sync_ctrl
    import scg_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic [CTRL_W-1:0]    ctrl_wdata,
    input  logic [NCH-1:0]       cnt_wr_oh,
    input  logic [NCH-1:0]       own_hit,
    input  logic [2*NCH-1:0]     clr_sel,
    output logic [NCH-1:0]       sync_q,
    output logic [NCH-1:0]       preset_en,
    output logic [NCH-1:0]       clr_en
);
    logic group_hit;
    logic set_wr;

    // Control register: only the sync bits are stored, upper bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)       sync_q <= '0;
        else if (ctrl_wr) sync_q <= ctrl_wdata[NCH-1:0];
    end

    // Set-wide events: a member write or a member own-compare clear.
    always_comb begin
        group_hit = |(sync_q & own_hit);
        set_wr    = |(sync_q & cnt_wr_oh);
    end

    // Per-channel enables derived from the set-wide events.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            preset_en[i] = cnt_wr_oh[i] || (sync_q[i] && set_wr);
            clr_en[i]    = own_hit[i] ||
                           (sync_q[i] && (clr_sel_e'(clr_sel[2*i +: 2]) == CLR_GROUP)
                            && group_hit);
        end
    end

    // R2: sync bits change only on a control write.
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(sync_q));
endmodule

// File: rtl/scg_channel.sv
// One counter channel: 16-bit up-counter plus compare register.
// Priority per cycle: preset, then clear, then increment.
// Assumes: preset_en and clr_en come from the sync control block.
module scg_channel
    import scg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           count_en,
    input  logic [1:0]     sel,
    input  logic           preset_en,
    input  logic [CW-1:0]  wdata,
    input  logic           cmp_wr,
    input  logic           clr_en,
    output logic [CW-1:0]  cnt_q,
    output logic [CW-1:0]  cmp_q,
    output logic           own_hit
);
    // Own compare hit only counts on an enabled edge with select 01.
    assign own_hit = count_en && (clr_sel_e'(sel) == CLR_OWN) && (cnt_q == cmp_q);

    // Counter update with preset > clear > increment priority.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (preset_en) cnt_q <= wdata;
        else if (clr_en)    cnt_q <= '0;
        else if (count_en)  cnt_q <= cnt_q + 1'b1;
    end

    // Compare register load from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_wr) cmp_q <= wdata;
    end

    // R10: a preset always lands, whatever else happens that cycle.
    a_r10_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        preset_en |=> cnt_q == $past(wdata));
    // R4: wrap from all ones to zero.
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        count_en && !preset_en && !clr_en && (cnt_q == '1) |=> cnt_q == '0);
    // R4: idle counter holds.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en && !preset_en && !clr_en |=> $stable(cnt_q));
    // R7: an own compare hit without a preset zeroes the counter.
    a_r7_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
        own_hit && !preset_en |=> cnt_q == '0);
endmodule

// File: rtl/sync_counter_group.sv
// Top of the counter group: NCH channels, sync control and register bus.
// Assumes: CW >= 8 so the control register fits the read data.
module sync_counter_group
    import scg_pkg::*;
#(
    parameter int NCH = 6,
    parameter int CW  = 16,
    parameter int AW  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               count_en,
    input  logic [2*NCH-1:0]   clr_sel,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_wr,
    input  logic [CW-1:0]      bus_wdata,
    output logic [CW-1:0]      bus_rdata
);
    localparam int CTRL_ADDR = 2 * NCH;

    logic [NCH-1:0][CW-1:0] cnt_all;
    logic [NCH-1:0][CW-1:0] cmp_all;
    logic [NCH-1:0]         sync_q;
    logic [NCH-1:0]         cnt_wr_oh;
    logic [NCH-1:0]         cmp_wr_oh;
    logic [NCH-1:0]         preset_en;
    logic [NCH-1:0]         clr_en;
    logic [NCH-1:0]         own_hit;
    logic                   ctrl_wr;

    // Bus decode and read mux.
    scg_regbus #(.NCH(NCH), .CW(CW), .AW(AW)) u_bus (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .cnt_all   (cnt_all),
        .cmp_all   (cmp_all),
        .sync_q    (sync_q),
        .cnt_wr_oh (cnt_wr_oh),
        .cmp_wr_oh (cmp_wr_oh),
        .ctrl_wr   (ctrl_wr),
        .rdata     (bus_rdata)
    );

    // Sync bits and group preset/clear fan-out.
    scg_sync_ctrl #(.NCH(NCH)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
        .cnt_wr_oh  (cnt_wr_oh),
        .own_hit    (own_hit),
        .clr_sel    (clr_sel),
        .sync_q     (sync_q),
        .preset_en  (preset_en),
        .clr_en     (clr_en)
    );

    // One channel instance per counter.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        scg_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .count_en  (count_en),
            .sel       (clr_sel[2*i +: 2]),
            .preset_en (preset_en[i]),
            .wdata     (bus_wdata),
            .cmp_wr    (cmp_wr_oh[i]),
            .clr_en    (clr_en[i]),
            .cnt_q     (cnt_all[i]),
            .cmp_q     (cmp_all[i]),
            .own_hit   (own_hit[i])
        );
    end

    // R6: two channels preset together hold equal counts afterwards.
    for (genvar i = 0; i < NCH; i++) begin : g_chk_i
        for (genvar j = i + 1; j < NCH; j++) begin : g_chk_j
            a_r6_preset_equal: assert property (@(posedge clk) disable iff (!rst_n)
                preset_en[i] && preset_en[j] |=> cnt_all[i] == cnt_all[j]);
        end
    end

    // R2: reserved control bits read back as zero.
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == AW'(CTRL_ADDR) |-> bus_rdata[CW-1:NCH] == '0);
endmodule

// File: tb/sim_sync_counter_group.sv
// Bench: a table of bus vectors walked by one loop, then directed tests.
module sim_sync_counter_group;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_en = 1'b0;
    logic [11:0] clr_sel = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sync_counter_group u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (count_en),
        .clr_sel   (clr_sel),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [15:0] wdata;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd0,  16'h0000, 16'h0000, 4'd1},  // R1 counter 0
        '{1'b0, 4'd6,  16'h0000, 16'h0000, 4'd1},  // R1 compare 0
        '{1'b0, 4'd12, 16'h0000, 16'h0000, 4'd1},  // R1 control
        '{1'b1, 4'd12, 16'h00C0, 16'h0000, 4'd2},  // R2 reserved bits
        '{1'b1, 4'd12, 16'h00FF, 16'h003F, 4'd2},  // R2
        '{1'b1, 4'd12, 16'h0000, 16'h0000, 4'd2},  // R2
        '{1'b1, 4'd7,  16'h1234, 16'h1234, 4'd3},  // R3 compare 1
        '{1'b1, 4'd1,  16'hABCD, 16'hABCD, 4'd3},  // R3 counter 1
        '{1'b0, 4'd0,  16'h0000, 16'h0000, 4'd5},  // R5
        '{1'b1, 4'd13, 16'h5555, 16'h0000, 4'd3},  // R3 unmapped
        '{1'b0, 4'd15, 16'h0000, 16'h0000, 4'd3},  // R3
        '{1'b0, 4'd7,  16'h0000, 16'h1234, 4'd3},  // R3 untouched
        '{1'b1, 4'd12, 16'h0015, 16'h0015, 4'd2},  // R2 set {4,2,0}
        '{1'b1, 4'd0,  16'h0100, 16'h0100, 4'd6},  // R6 group preset
        '{1'b0, 4'd2,  16'h0000, 16'h0100, 4'd6},  // R6
        '{1'b0, 4'd4,  16'h0000, 16'h0100, 4'd6},  // R6
        '{1'b0, 4'd1,  16'h0000, 16'hABCD, 4'd5},  // R5
        '{1'b0, 4'd3,  16'h0000, 16'h0000, 4'd5},  // R5
        '{1'b1, 4'd3,  16'h0077, 16'h0077, 4'd5},  // R5 lone write
        '{1'b0, 4'd0,  16'h0000, 16'h0100, 4'd5},  // R5
        '{1'b1, 4'd4,  16'h0200, 16'h0200, 4'd6},  // R6 from another member
        '{1'b0, 4'd0,  16'h0000, 16'h0200, 4'd6}   // R6
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic run(input int n);
        @(negedge clk);
        count_en = 1'b1;
        repeat (n) @(negedge clk);
        count_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; count_en = 1'b0; bus_wr = 1'b0; clr_sel = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // Vector table walk: register map, sync bits, group presets.
        for (int k = 0; k < NV; k++) begin
            if (VEC[k].wr) wr(VEC[k].addr, VEC[k].wdata);
            else @(negedge clk);
            rd_chk($sformatf("R%0d vec%0d", VEC[k].req, k), VEC[k].addr, VEC[k].exp);
        end

        // R4: wrap and hold.
        do_reset();
        wr(4'd3, 16'hFFFE);
        run(3);
        rd_chk("R4 wrap", 4'd3, 16'h0001);
        rd_chk("R4 count", 4'd0, 16'h0003);
        repeat (3) @(negedge clk);
        rd_chk("R4 hold", 4'd0, 16'h0003);

        // R7 own clear, R9 selects 11 and 00 never clear.
        do_reset();
        clr_sel = 12'b00_00_00_00_11_01;
        clr_sel[5:4] = 2'b00;
        wr(4'd6, 16'd5);
        wr(4'd7, 16'd5);
        wr(4'd8, 16'd5);
        run(6);
        rd_chk("R7 own clear", 4'd0, 16'h0000);
        rd_chk("R9 select 11", 4'd1, 16'h0006);
        rd_chk("R9 select 00", 4'd2, 16'h0006);

        // R8 group clear: set {0,1,2}, ch0 source, ch1 follower, ch3 unsynced follower.
        do_reset();
        clr_sel = 12'b00_00_10_00_10_01;
        wr(4'd12, 16'h0007);
        wr(4'd6, 16'd3);
        wr(4'd3, 16'h0020);
        run(4);
        rd_chk("R8 source", 4'd0, 16'h0000);
        rd_chk("R8 follower", 4'd1, 16'h0000);
        rd_chk("R8 member sel00", 4'd2, 16'h0004);
        rd_chk("R8 unsynced", 4'd3, 16'h0024);
        rd_chk("R5 outside set", 4'd4, 16'h0004);

        // R10: write, own match, group clear and counting in one cycle.
        do_reset();
        clr_sel = 12'b00_00_00_10_00_01;
        wr(4'd12, 16'h0005);
        @(negedge clk);
        count_en = 1'b1; bus_addr = 4'd0; bus_wdata = 16'h0040; bus_wr = 1'b1;
        @(negedge clk);
        count_en = 1'b0; bus_wr = 1'b0;
        rd_chk("R10 over own clear", 4'd0, 16'h0040);
        rd_chk("R10 over group clear", 4'd2, 16'h0040);
        rd_chk("R10 others count", 4'd1, 16'h0001);

        // R11: single sync bit acts alone.
        do_reset();
        wr(4'd12, 16'h0002);
        wr(4'd1, 16'h0050);
        rd_chk("R11 written", 4'd1, 16'h0050);
        rd_chk("R11 ch0", 4'd0, 16'h0000);
        rd_chk("R11 ch2", 4'd2, 16'h0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule